// File: doc/BRIEF.md
# Transmit-Sample Frame Receiver with Command Decode

This block is the slave end of a serial link that feeds a DAC with samples. A conversion strobe starts each 16-bit frame. Every frame carries a 4-bit command, two unused bit slots, and a 10-bit sample. The three link wires (serial clock, strobe, data) are sampled in the block's own clock domain. That clock must run at least four times faster than the serial clock, and the inputs are assumed free of metastability. Two configuration inputs tune the framing. One picks the serial clock edge on which the strobe is seen. The other delays the first data bit by one serial clock.

A frame whose command has its top bit clear is a normal frame. It produces a one-cycle sample-valid strobe with the sample. When dynamic gain is enabled, it may also change the 4-bit gain register through a non-linear mapping. Frames whose command has its top bit set give indirect register access. One command sets a 7-bit address and a direction flag. A second latches a high byte. A third supplies the low byte, issues a 16-bit register write and steps the address. The remaining codes with the top bit set are reserved and ignored.

Top module: `txlink_frame_rx`

## Requirements
- R1: After reset the gain output is 4'b0101, and neither sample-valid nor write-enable pulses until a complete frame has been received.
- R2: Frame bits are captured MSB first on falling serial clock edges. Bits [15:12] are the command, [11:10] are ignored and [9:0] are the sample. In indirect frames, the byte in bits [7:0] is the payload.
- R3: A frame starts when the strobe is seen high at one sampling edge and low at the next. The sampling edge is the falling serial clock edge when cfg_conv_rise=0 and the rising edge when cfg_conv_rise=1.
- R4: With cfg_first_dly=0, the first data bit is taken on the first falling edge at or after the detected strobe fall. With cfg_first_dly=1, one falling edge is skipped first.
- R5: A complete frame with command bit 3 = 0 produces exactly one single-cycle smp_vld pulse, with smp_data equal to bits [9:0].
- R6: In a normal frame with cfg_dyn_gain=1, command bits [2:0] set the gain. 000 leaves it unchanged, 001/010/011 give 0001/0010/0011, and 100/101/110/111 give 0101/0110/0111/1000. With cfg_dyn_gain=0 the gain never changes.
- R7: Command 4'b1000 loads the indirect address from payload bits [7:1] and the direction flag from payload bit 0 (0 = write, 1 = read).
- R8: Command 4'b1010 stores the payload as the high byte of the indirect data.
- R9: Command 4'b1011 with the direction flag at 0 gives a single-cycle wr_en, with wr_addr set to the indirect address and wr_data set to {high byte, payload}. The address then increments modulo 128. With the flag at 1, it causes neither a write nor an increment.
- R10: Commands 4'b1001 and 4'b11xx change no output and no internal state.
- R11: A strobe fall during an unfinished frame discards the partial frame and starts a new one.
- R12: Frames with command bit 3 = 1 never produce smp_vld, and wr_en and smp_vld are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_conv_rise | input | 1 | Strobe sampling edge: 0 falling, 1 rising |
| cfg_first_dly | input | 1 | Delay first data bit by one serial clock |
| cfg_dyn_gain | input | 1 | Allow normal frames to change the gain |
| ser_clk | input | 1 | Serial link clock |
| ser_conv | input | 1 | Conversion strobe, frame starts on its fall |
| ser_dat | input | 1 | Serial data |
| smp_vld | output | 1 | One-cycle pulse per normal frame |
| smp_data | output | 10 | Received sample |
| gain | output | 4 | Predriver gain code |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 7 | Register write address |
| wr_data | output | 16 | Register write data |

## Verification
The hardest situation to reach is a strobe fall that lands inside a running frame in a configuration where the start detection and the first data bit share one serial clock edge. There the restart and the capture of bit 0 must happen in the same cycle. The bench cuts a frame short after nine bits and follows it at once with a full frame. It also covers every pairing of strobe edge and first-bit delay, so each alignment path between strobe detection and bit capture is exercised. Address wrap is reached directly by setting the address to 127 before two low-byte writes.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int CMD_W   = 4;
    localparam int PAD_W   = 2;
    localparam int SMP_W   = 10;
    localparam int FRAME_W = CMD_W + PAD_W + SMP_W;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = BYTE_W - 1;
    localparam int WDATA_W = 2 * BYTE_W;
    localparam int GAIN_W  = 4;

    localparam logic [GAIN_W-1:0] GAIN_RESET = 4'b0101;
    localparam logic [GAIN_W-1:0] GAIN_MAX   = 4'b1000;

    localparam logic [CMD_W-1:0] CMD_SET_ADDR = 4'b1000;
    localparam logic [CMD_W-1:0] CMD_HI_BYTE  = 4'b1010;
    localparam logic [CMD_W-1:0] CMD_LO_BYTE  = 4'b1011;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [PAD_W-1:0] pad;
        logic [SMP_W-1:0] smp;
    } frame_t;

    // Gain selection skips code 0100 on the upper half of the selector.
    function automatic logic [GAIN_W-1:0] next_gain(input logic [CMD_W-2:0] sel,
                                                    input logic [GAIN_W-1:0] cur);
        logic [GAIN_W-1:0] ext;
        ext = GAIN_W'(sel);
        if (sel == '0)
            return cur;
        else if (!sel[CMD_W-2])
            return ext;
        else
            return ext + GAIN_W'(1);
    endfunction
endpackage

// File: rtl/fsr_edge_detect.sv
module fsr_edge_detect
    import fsr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_conv_rise,
    input  logic ser_clk,
    input  logic ser_conv,
    input  logic ser_dat,
    output logic bit_tick,
    output logic conv_tick,
    output logic conv_lvl,
    output logic dat_lvl
);
    logic clk_q, clk_qq;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q    <= 1'b0;
            clk_qq   <= 1'b0;
            conv_lvl <= 1'b0;
            dat_lvl  <= 1'b0;
        end else begin
            clk_q    <= ser_clk;
            clk_qq   <= clk_q;
            conv_lvl <= ser_conv;
            dat_lvl  <= ser_dat;
        end
    end

    logic fall_seen, rise_seen;
    always_comb begin
        fall_seen = clk_qq & ~clk_q;
        rise_seen = ~clk_qq & clk_q;
        bit_tick  = fall_seen;
        conv_tick = cfg_conv_rise ? rise_seen : fall_seen;
    end
endmodule

// File: rtl/fsr_framer.sv
module fsr_framer
    import fsr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cfg_first_dly,
    input  logic   bit_tick,
    input  logic   conv_tick,
    input  logic   conv_lvl,
    input  logic   dat_lvl,
    output logic   frame_vld,
    output frame_t frame
);
    logic               conv_last;
    logic               active;
    logic               skip;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-2:0] shreg;
    logic               start;

    assign start = conv_tick & conv_last & ~conv_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_last <= 1'b0;
            active    <= 1'b0;
            skip      <= 1'b0;
            cnt       <= '0;
            shreg     <= '0;
            frame_vld <= 1'b0;
            frame     <= '0;
        end else begin
            frame_vld <= 1'b0;
            if (conv_tick)
                conv_last <= conv_lvl;
            if (start) begin
                // new frame; any partial frame is dropped
                active <= 1'b1;
                cnt    <= '0;
                skip   <= cfg_first_dly;
                if (bit_tick) begin
                    if (cfg_first_dly) begin
                        skip <= 1'b0;
                    end else begin
                        shreg <= {shreg[FRAME_W-3:0], dat_lvl};
                        cnt   <= CNT_W'(1);
                    end
                end
            end else if (active && bit_tick) begin
                if (skip) begin
                    skip <= 1'b0;
                end else begin
                    shreg <= {shreg[FRAME_W-3:0], dat_lvl};
                    if (cnt == CNT_W'(FRAME_W - 1)) begin
                        active    <= 1'b0;
                        frame_vld <= 1'b1;
                        frame     <= frame_t'({shreg, dat_lvl});
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/fsr_decoder.sv
module fsr_decoder
    import fsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_dyn_gain,
    input  logic               frame_vld,
    input  frame_t             frame,
    output logic               smp_vld,
    output logic [SMP_W-1:0]   smp_data,
    output logic [GAIN_W-1:0]  gain,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [WDATA_W-1:0] wr_data
);
    logic [ADDR_W-1:0] ind_addr;
    logic              ind_read;
    logic [BYTE_W-1:0] ind_hi;
    logic [BYTE_W-1:0] payload;

    assign payload = frame.smp[BYTE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_vld  <= 1'b0;
            smp_data <= '0;
            gain     <= GAIN_RESET;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            ind_addr <= '0;
            ind_read <= 1'b0;
            ind_hi   <= '0;
        end else begin
            smp_vld <= 1'b0;
            wr_en   <= 1'b0;
            if (frame_vld) begin
                if (!frame.cmd[CMD_W-1]) begin
                    smp_vld  <= 1'b1;
                    smp_data <= frame.smp;
                    if (cfg_dyn_gain)
                        gain <= next_gain(frame.cmd[CMD_W-2:0], gain);
                end else begin
                    case (frame.cmd)
                        CMD_SET_ADDR: begin
                            ind_addr <= payload[BYTE_W-1:1];
                            ind_read <= payload[0];
                        end
                        CMD_HI_BYTE: ind_hi <= payload;
                        CMD_LO_BYTE: begin
                            if (!ind_read) begin
                                wr_en    <= 1'b1;
                                wr_addr  <= ind_addr;
                                wr_data  <= {ind_hi, payload};
                                ind_addr <= ind_addr + ADDR_W'(1);
                            end
                        end
                        default: ;  // reserved codes
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/txlink_frame_rx.sv
module txlink_frame_rx
    import fsr_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_conv_rise,
    input  logic               cfg_first_dly,
    input  logic               cfg_dyn_gain,
    input  logic               ser_clk,
    input  logic               ser_conv,
    input  logic               ser_dat,
    output logic               smp_vld,
    output logic [SMP_W-1:0]   smp_data,
    output logic [GAIN_W-1:0]  gain,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [WDATA_W-1:0] wr_data
);
    logic   bit_tick, conv_tick, conv_lvl, dat_lvl;
    logic   frame_vld;
    frame_t frame;

    fsr_edge_detect edge_i (
        .clk(clk), .rst(rst), .cfg_conv_rise(cfg_conv_rise),
        .ser_clk(ser_clk), .ser_conv(ser_conv), .ser_dat(ser_dat),
        .bit_tick(bit_tick), .conv_tick(conv_tick),
        .conv_lvl(conv_lvl), .dat_lvl(dat_lvl)
    );

    fsr_framer framer_i (
        .clk(clk), .rst(rst), .cfg_first_dly(cfg_first_dly),
        .bit_tick(bit_tick), .conv_tick(conv_tick),
        .conv_lvl(conv_lvl), .dat_lvl(dat_lvl),
        .frame_vld(frame_vld), .frame(frame)
    );

    fsr_decoder decode_i (
        .clk(clk), .rst(rst), .cfg_dyn_gain(cfg_dyn_gain),
        .frame_vld(frame_vld), .frame(frame),
        .smp_vld(smp_vld), .smp_data(smp_data), .gain(gain),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );
endmodule

// File: rtl/txlink_frame_rx_chk.sv
module txlink_frame_rx_chk
    import fsr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_dyn_gain,
    input logic              smp_vld,
    input logic [GAIN_W-1:0] gain,
    input logic              wr_en
);
    a_r1_gain_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> gain == GAIN_RESET);

    a_r6_gain_range: assert property (@(posedge clk) disable iff (rst)
        gain <= GAIN_MAX);

    a_r6_gain_static: assert property (@(posedge clk) disable iff (rst)
        !cfg_dyn_gain |=> $stable(gain));

    a_r5_vld_single: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> !smp_vld);

    a_r9_wr_single: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    a_r12_excl: assert property (@(posedge clk) disable iff (rst)
        !(smp_vld && wr_en));
endmodule

bind txlink_frame_rx txlink_frame_rx_chk chk_i (
    .clk(clk), .rst(rst), .cfg_dyn_gain(cfg_dyn_gain),
    .smp_vld(smp_vld), .gain(gain), .wr_en(wr_en)
);

// File: tb/txlink_frame_rx_tb_top.sv
module txlink_frame_rx_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic cfg_conv_rise = 1'b0, cfg_first_dly = 1'b0, cfg_dyn_gain = 1'b1;
    logic ser_clk = 1'b0, ser_conv = 1'b0, ser_dat = 1'b0;
    logic        smp_vld, wr_en;
    logic [9:0]  smp_data;
    logic [3:0]  gain;
    logic [6:0]  wr_addr;
    logic [15:0] wr_data;

    txlink_frame_rx dut_i (
        .clk(clk), .rst(rst), .cfg_conv_rise(cfg_conv_rise),
        .cfg_first_dly(cfg_first_dly), .cfg_dyn_gain(cfg_dyn_gain),
        .ser_clk(ser_clk), .ser_conv(ser_conv), .ser_dat(ser_dat),
        .smp_vld(smp_vld), .smp_data(smp_data), .gain(gain),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    int checks = 0, errors = 0;
    int vld_cnt = 0, wr_cnt = 0;
    logic [9:0]  last_smp = '0;
    logic [6:0]  last_waddr = '0;
    logic [15:0] last_wdata = '0;
    bit done = 0;

    // bench model
    logic [3:0] m_gain = 4'b0101;
    logic [6:0] m_addr = '0;
    logic       m_rd = 1'b0;
    logic [7:0] m_hi = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (smp_vld) begin vld_cnt++; last_smp = smp_data; end
            if (wr_en) begin wr_cnt++; last_waddr = wr_addr; last_wdata = wr_data; end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] gain_model(input logic [2:0] s, input logic [3:0] cur);
        case (s)
            3'd0: return cur;
            3'd1: return 4'b0001;
            3'd2: return 4'b0010;
            3'd3: return 4'b0011;
            3'd4: return 4'b0101;
            3'd5: return 4'b0110;
            3'd6: return 4'b0111;
            default: return 4'b1000;
        endcase
    endfunction

    // one serial clock: rise, data change a quarter later, fall at half
    task automatic run_cycle(input logic c, input logic d);
        @(negedge clk) ser_clk = 1'b1;
        @(negedge clk);
        @(negedge clk) begin ser_conv = c; ser_dat = d; end
        @(negedge clk);
        @(negedge clk) ser_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_bits(input logic [15:0] w, input int nbits);
        int lead;
        lead = int'(cfg_conv_rise) + int'(cfg_first_dly);
        run_cycle(1'b1, 1'b0);
        for (int j = 0; j < lead; j++) run_cycle(1'b0, 1'b0);
        for (int i = 0; i < nbits; i++) run_cycle(1'b0, w[15-i]);
    endtask

    task automatic do_frame(input logic [15:0] w, input string tag);
        int v0, w0, ev, ew;
        logic [6:0]  ea;
        logic [15:0] ed;
        v0 = vld_cnt; w0 = wr_cnt; ev = 0; ew = 0; ea = '0; ed = '0;
        send_bits(w, 16);
        repeat (3) run_cycle(1'b0, 1'b0);
        if (!w[15]) begin
            ev = 1;
            if (cfg_dyn_gain) m_gain = gain_model(w[14:12], m_gain);
        end else if (w[15:12] == 4'b1000) begin
            m_addr = w[7:1]; m_rd = w[0];
        end else if (w[15:12] == 4'b1010) begin
            m_hi = w[7:0];
        end else if (w[15:12] == 4'b1011 && !m_rd) begin
            ew = 1; ea = m_addr; ed = {m_hi, w[7:0]}; m_addr = m_addr + 7'd1;
        end
        check({tag, " R5 R12 sample strobe count"}, vld_cnt - v0, ev);
        if (ev == 1) check({tag, " R2 R5 sample value"}, int'(last_smp), int'(w[9:0]));
        check({tag, " R9 R10 write count"}, wr_cnt - w0, ew);
        if (ew == 1) begin
            check({tag, " R9 write address"}, int'(last_waddr), int'(ea));
            check({tag, " R8 R9 write data"}, int'(last_wdata), int'(ed));
        end
        check({tag, " R6 gain"}, int'(gain), int'(m_gain));
    endtask

    task automatic set_cfg(input logic r, input logic d, input logic g);
        @(negedge clk) begin cfg_conv_rise = r; cfg_first_dly = d; cfg_dyn_gain = g; end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset gain", int'(gain), 5);
        check("R1 reset smp_vld", int'(smp_vld), 0);
        check("R1 reset wr_en", int'(wr_en), 0);

        // R6: every selector code, dynamic gain on (falling edge, no delay)
        set_cfg(1'b0, 1'b0, 1'b1);
        for (int c = 0; c < 8; c++)
            do_frame({1'b0, 3'(c), 2'b11, 10'(c * 97 + 5)}, "R6 map");
        do_frame({4'b0011, 2'b00, 10'h155}, "R6 map 011");
        // R6: dynamic gain off
        set_cfg(1'b0, 1'b0, 1'b0);
        do_frame({4'b0111, 2'b00, 10'h0AA}, "R6 static");

        // R3/R4: every strobe edge and delay pairing
        set_cfg(1'b1, 1'b0, 1'b1);
        do_frame({4'b0000, 2'b10, 10'h2A5}, "R3 rise nodly");
        set_cfg(1'b0, 1'b1, 1'b1);
        do_frame({4'b0001, 2'b01, 10'h15A}, "R4 fall dly");
        set_cfg(1'b1, 1'b1, 1'b1);
        do_frame({4'b0110, 2'b11, 10'h3FF}, "R3 R4 rise dly");

        // R7/R8/R9: indirect writes with wrap
        set_cfg(1'b0, 1'b0, 1'b1);
        do_frame({4'b1000, 4'h0, 7'h7F, 1'b0}, "R7 addr");
        do_frame({4'b1010, 4'h0, 8'hC3}, "R8 hi");
        do_frame({4'b1011, 4'h0, 8'h5A}, "R9 lo");
        do_frame({4'b1011, 4'h0, 8'h11}, "R9 wrap");
        // R9: read flag set, no write
        do_frame({4'b1000, 4'h0, 7'h10, 1'b1}, "R7 addr read");
        do_frame({4'b1011, 4'h0, 8'h22}, "R9 read no write");
        do_frame({4'b1000, 4'h0, 7'h10, 1'b0}, "R7 addr write");
        do_frame({4'b1011, 4'h0, 8'h33}, "R9 after read");

        // R10: reserved codes leave state alone
        do_frame({4'b1001, 4'h0, 8'hEE}, "R10 1001");
        do_frame({4'b1100, 4'h0, 8'hDD}, "R10 1100");
        do_frame({4'b1111, 4'h0, 8'hBB}, "R10 1111");
        do_frame({4'b1011, 4'h0, 8'h44}, "R10 state kept");

        // R11: truncated frame discarded, same-edge restart
        send_bits({4'b0101, 2'b00, 10'h3C3}, 9);
        do_frame({4'b0010, 2'b00, 10'h0F0}, "R11 restart");
        set_cfg(1'b1, 1'b1, 1'b1);
        send_bits({4'b1011, 4'h0, 8'h99}, 12);
        do_frame({4'b0000, 2'b00, 10'h111}, "R11 restart rise");

        // random mix
        for (int k = 0; k < 40; k++) begin
            logic [15:0] w;
            int kind;
            set_cfg(1'($urandom), 1'($urandom), ($urandom % 4) != 0);
            kind = $urandom % 6;
            w = 16'($urandom);
            case (kind)
                0, 1, 2: w[15] = 1'b0;
                3:       begin w[15:12] = 4'b1000; w[0] = ($urandom % 4) == 0; end
                4:       w[15:12] = (($urandom % 2) == 0) ? 4'b1010 : 4'b1011;
                default: w[15:12] = (($urandom % 2) == 0) ? 4'b1001 : {2'b11, 2'($urandom)};
            endcase
            do_frame(w, "rand");
        end

        finish_run();
    end
endmodule